// File: doc/BRIEF.md
# Stereo Sample Mixer with Direct DAC Channel

This block turns six synthesizer channel words into one stereo sample pair. Each channel word is cut down to a 9-bit field, sign-extended, halved, and added into the left sum, the right sum or both, as its two pan bits select. The mixer does not emit a pair on every frame. A fractional phase accumulator advances by a programmable increment on each frame pulse, and a pair is produced only when the accumulator passes one. This is how a fixed synthesis frame rate is brought down to an output sample rate.

Channel 5 can be switched to a direct-DAC source. While DAC mode is on, channel 5's input word is ignored. Its place is taken by a held register that is loaded from 8-bit offset-binary writes, and writes made while DAC mode is off are discarded.

Top module: `stereo_mix`

## Requirements
- R1: After reset, `sampleLeft`, `sampleRight` and `sampleValid` are 0, the phase accumulator is 0, DAC mode is off and the held DAC word is 0.
- R2: A channel word w contributes c = m >> 1 (logical shift, zero into bit 15). Here m = (w & 0x3FE0) with bit 13 of that result copied into bits 15 and 14. For example, 0x1FFF gives 0x0FF0, 0x2000 gives 0x7000 and 0x001F gives 0.
- R3: `chanPan[i][1]` adds channel i into the left sum, and `chanPan[i][0]` adds it into the right sum. With a bit clear, that channel does not touch that side.
- R4: For every emitted pair, each side's sum starts at zero and is the modulo-2^16 total of its enabled contributions.
- R5: On a cycle with `framePulse` high, the accumulator (16 fractional bits, 0x10000 = 1.0) adds `sampleInc`. If the result is greater than 0x10000, 0x10000 is subtracted and a pair is emitted. The pair appears on the outputs with `sampleValid` high in the cycle after the pulse, and `sampleValid` stays high for one cycle only. `sampleInc` must not exceed 0x10000.
- R6: Without an emission, the accumulator keeps its value when there is no pulse, and the outputs hold the last emitted pair whatever the channel inputs do.
- R7: A cycle with `dacCtrlWr` high sets DAC mode to `dacModeIn`. While DAC mode is on, channel 5's contribution is computed from the held DAC word in place of `chanOut[5]`.
- R8: A cycle with `dacDataWr` high while DAC mode is on loads the held DAC word with (`dacData` − 0x80) × 64 in 16 bits. If DAC mode is off, the write is ignored.
- R9: An accumulator result exactly equal to 0x10000 does not emit and is kept as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanOut | input | 6x16 | Channel output words, index = channel |
| chanPan | input | 6x2 | Per-channel pan: bit 1 left, bit 0 right |
| dacCtrlWr | input | 1 | Strobe: update DAC mode |
| dacModeIn | input | 1 | New DAC mode (the enable register's top bit) |
| dacDataWr | input | 1 | Strobe: DAC data write |
| dacData | input | 8 | Offset-binary DAC data |
| framePulse | input | 1 | One pulse per synthesis frame |
| sampleInc | input | 17 | Accumulator increment, 16 fractional bits |
| sampleLeft | output | 16 | Left sample, two's complement |
| sampleRight | output | 16 | Right sample, two's complement |
| sampleValid | output | 1 | New pair present this cycle |

## Verification
A wrong accumulator value shows at the ports as a `sampleValid` pulse that comes one or more frame pulses early or late. Once the increment is fixed, that error repeats every cycle of the rate pattern. A wrong DAC mode bit or a wrong held DAC word stays hidden until the next emitted pair, which then carries a wrong channel-5 share. Errors in field extraction or summing show up in the very pair being emitted, one cycle after the pulse.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SIGN_BIT = 13;
  localparam int LOW_CLR  = 5;
  localparam logic [SAMPLE_W-1:0] FIELD_MASK =
    SAMPLE_W'(((1 << (SIGN_BIT + 1)) - 1) & ~((1 << LOW_CLR) - 1));
  localparam int DAC_SHIFT = 6;
  localparam logic [SAMPLE_W-1:0] DAC_OFFSET = 16'h0080;

  typedef struct packed {
    logic emit;     // produce a sample pair this cycle
    logic dacLoad;  // load held DAC word
    logic dacSel;   // channel DAC_CH sourced from DAC word
  } mix_strobe_t;
endpackage

// File: rtl/mix_ctrl.sv
module mix_ctrl
  import mix_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic [FRAC_W:0]   sampleInc,
  input  logic              dacCtrlWr,
  input  logic              dacModeIn,
  input  logic              dacDataWr,
  output mix_strobe_t       strb
);
  localparam int ACC_W = FRAC_W + 1;
  localparam logic [ACC_W:0] ONE = (ACC_W+1)'(1) << FRAC_W;

  logic [ACC_W-1:0] phaseAcc;
  logic [ACC_W:0]   phaseSum;
  logic             passOne;
  logic             dacOn;

  assign phaseSum = {1'b0, phaseAcc} + {1'b0, sampleInc};
  assign passOne  = phaseSum > ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
    end else if (framePulse) begin
      if (passOne) phaseAcc <= ACC_W'(phaseSum - ONE);
      else         phaseAcc <= phaseSum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          dacOn <= 1'b0;
    else if (dacCtrlWr) dacOn <= dacModeIn;
  end

  always_comb begin
    strb         = '0;
    strb.emit    = framePulse && passOne;
    strb.dacLoad = dacDataWr && dacOn;
    strb.dacSel  = dacOn;
  end

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, phaseAcc} <= ONE);

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !framePulse |=> $stable(phaseAcc));
endmodule

// File: rtl/mix_datapath.sv
module mix_datapath
  import mix_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DAC_CH = 5
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  mix_strobe_t                        strb,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]    chanOut,
  input  logic [NUM_CH-1:0][1:0]             chanPan,
  input  logic [7:0]                         dacData,
  output logic [SAMPLE_W-1:0]                sampleLeft,
  output logic [SAMPLE_W-1:0]                sampleRight,
  output logic                               sampleValid
);
  localparam int EXT_W = SAMPLE_W - 1 - SIGN_BIT;

  logic [SAMPLE_W-1:0]              dacWord;
  logic [SAMPLE_W-1:0]              dacCalc;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]  halfVal;
  logic [SAMPLE_W-1:0]              sumLeft, sumRight;

  assign dacCalc = SAMPLE_W'(({8'h00, dacData} - DAC_OFFSET) << DAC_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN)             dacWord <= '0;
    else if (strb.dacLoad) dacWord <= dacCalc;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [SAMPLE_W-1:0] srcWord, fieldVal, extVal;
    if (i == DAC_CH) begin : g_dac
      assign srcWord = strb.dacSel ? dacWord : chanOut[i];
    end else begin : g_plain
      assign srcWord = chanOut[i];
    end
    assign fieldVal   = srcWord & FIELD_MASK;
    assign extVal     = {{EXT_W{fieldVal[SIGN_BIT]}}, fieldVal[SIGN_BIT:0]};
    assign halfVal[i] = extVal >> 1;
  end

  always_comb begin
    sumLeft  = '0;
    sumRight = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chanPan[i][1]) sumLeft  = sumLeft  + halfVal[i];
      if (chanPan[i][0]) sumRight = sumRight + halfVal[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleLeft  <= '0;
      sampleRight <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strb.emit;
      if (strb.emit) begin
        sampleLeft  <= sumLeft;
        sampleRight <= sumRight;
      end
    end
  end

  // R8
  dac_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacWord[DAC_SHIFT-1:0] == '0);

  // R8
  dac_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dacLoad |=> $stable(dacWord));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.emit |=> ($stable(sampleLeft) && $stable(sampleRight)));
endmodule

// File: rtl/stereo_mix.sv
module stereo_mix
  import mix_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DAC_CH = 5,
  parameter int FRAC_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  chanOut,
  input  logic [NUM_CH-1:0][1:0]           chanPan,
  input  logic                             dacCtrlWr,
  input  logic                             dacModeIn,
  input  logic                             dacDataWr,
  input  logic [7:0]                       dacData,
  input  logic                             framePulse,
  input  logic [FRAC_W:0]                  sampleInc,
  output logic [SAMPLE_W-1:0]              sampleLeft,
  output logic [SAMPLE_W-1:0]              sampleRight,
  output logic                             sampleValid
);
  mix_strobe_t strb;

  mix_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .sampleInc(sampleInc),
    .dacCtrlWr(dacCtrlWr), .dacModeIn(dacModeIn), .dacDataWr(dacDataWr),
    .strb(strb)
  );

  mix_datapath #(.NUM_CH(NUM_CH), .DAC_CH(DAC_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chanOut(chanOut), .chanPan(chanPan),
    .dacData(dacData), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleValid(sampleValid)
  );

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(framePulse));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid || $past(framePulse));
endmodule

// File: tb/tb_stereo_mix.sv
module tb_stereo_mix;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0][15:0] chanOut = '0;
  logic [5:0][1:0]  chanPan = '0;
  logic dacCtrlWr = 1'b0, dacModeIn = 1'b0, dacDataWr = 1'b0;
  logic [7:0] dacData = '0;
  logic framePulse = 1'b0;
  logic [16:0] sampleInc = '0;
  logic [15:0] sampleLeft, sampleRight;
  logic sampleValid;

  int checks = 0;
  int fails = 0;

  logic [16:0] mAcc = '0;
  logic        mDacOn = 1'b0;
  logic [15:0] mDacVal = '0;
  logic [15:0] mOutL = '0, mOutR = '0;

  always #2 clk = ~clk;

  stereo_mix dut (
    .clk(clk), .rstN(rstN), .chanOut(chanOut), .chanPan(chanPan),
    .dacCtrlWr(dacCtrlWr), .dacModeIn(dacModeIn), .dacDataWr(dacDataWr),
    .dacData(dacData), .framePulse(framePulse), .sampleInc(sampleInc),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight), .sampleValid(sampleValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] contrib(input logic [15:0] w);
    logic [15:0] m;
    m = w & 16'h3FE0;
    if (m[13]) m = m | 16'hC000;
    return m >> 1;
  endfunction

  function automatic logic [15:0] mixSide(input int side);
    logic [15:0] s;
    logic [15:0] src;
    s = '0;
    for (int i = 0; i < 6; i++) begin
      src = (i == 5 && mDacOn) ? mDacVal : chanOut[i];
      if (chanPan[i][side]) s = s + contrib(src);
    end
    return s;
  endfunction

  // one frame pulse; checks valid and outputs against the model
  task automatic pulse(input string req);
    logic [17:0] sum;
    logic emit;
    logic [15:0] eL, eR;
    sum  = {1'b0, mAcc} + {1'b0, sampleInc};
    emit = sum > 18'h10000;
    eL = mixSide(1);
    eR = mixSide(0);
    framePulse = 1'b1;
    @(negedge clk);
    framePulse = 1'b0;
    if (emit) begin
      mAcc = 17'(sum - 18'h10000);
      mOutL = eL; mOutR = eR;
    end else begin
      mAcc = sum[16:0];
    end
    chk({req, " valid"}, 32'(sampleValid), 32'(emit));
    chk({req, " left"},  32'(sampleLeft),  32'(mOutL));
    chk({req, " right"}, 32'(sampleRight), 32'(mOutR));
  endtask

  task automatic setDacMode(input logic on);
    dacCtrlWr = 1'b1; dacModeIn = on;
    @(negedge clk);
    dacCtrlWr = 1'b0;
    mDacOn = on;
  endtask

  task automatic writeDac(input logic [7:0] b);
    dacDataWr = 1'b1; dacData = b;
    @(negedge clk);
    dacDataWr = 1'b0;
    if (mDacOn) mDacVal = 16'(({8'h00, b} - 16'h0080) << 6);
  endtask

  task automatic t_reset;
    chk("R1 left", 32'(sampleLeft), 0);
    chk("R1 right", 32'(sampleRight), 0);
    chk("R1 valid", 32'(sampleValid), 0);
  endtask

  task automatic t_exactOne;
    chanPan = {6{2'b11}};
    chanOut[0] = 16'h1FFF;
    sampleInc = 17'h10000;
    pulse("R9 exact one, R1 acc zero");
    chk("R9 no emit at 1.0", 32'(sampleValid), 0);
    pulse("R5 emit past one");
    @(negedge clk);
    chk("R5 valid one cycle", 32'(sampleValid), 0);
  endtask

  task automatic t_shape;
    chanOut = '0;
    chanPan = {6{2'b11}};
    chanOut[0] = 16'h1FFF;
    pulse("R2 positive field");
    chk("R2 0x1FFF gives 0x0FF0", 32'(sampleLeft), 32'h0FF0);
    chanOut[0] = 16'h2000;
    pulse("R2 sign extend");
    chk("R2 0x2000 gives 0x7000", 32'(sampleLeft), 32'h7000);
    chanOut[0] = 16'h001F;
    chanOut[1] = 16'hC03F;
    pulse("R2 low bits and upper bits cleared");
    chk("R2 masked sum", 32'(sampleRight), 32'h0010);
  endtask

  task automatic t_pan;
    chanOut = {16'h0100, 16'h0200, 16'h0400, 16'h0800, 16'h1000, 16'h0040};
    chanPan = {2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01};
    pulse("R3 mixed pan");
    chk("R3 left sum", 32'(sampleLeft), 32'h0C80);
    chk("R3 right sum", 32'(sampleRight), 32'h0520);
    chanPan = {6{2'b00}};
    pulse("R3 all muted");
  endtask

  task automatic t_wrap;
    chanPan = {6{2'b11}};
    chanOut = {6{16'h2000}};
    pulse("R4 negative wrap");
    chk("R4 wrapped left", 32'(sampleLeft), 32'hA000);
    pulse("R4 fresh sum each pair");
    chk("R4 not accumulated", 32'(sampleRight), 32'hA000);
    chanOut = {6{16'h1FE0}};
    pulse("R4 positive sum");
  endtask

  task automatic t_rate;
    sampleInc = 17'h04000;
    chanOut = '0;
    chanOut[2] = 16'h0800;
    chanPan = '0;
    chanPan[2] = 2'b11;
    for (int k = 0; k < 12; k++) begin
      chanOut[2] = chanOut[2] + 16'h0020;
      pulse("R5 quarter rate");
      for (int j = 0; j < 2; j++) begin
        chanOut[3] = 16'(k * 64 + j);
        chanPan[3] = 2'b10;
        @(negedge clk);
        chk("R6 idle no valid", 32'(sampleValid), 0);
        chk("R6 idle left held", 32'(sampleLeft), 32'(mOutL));
      end
      chanPan[3] = 2'b00;
    end
    sampleInc = 17'h0C000;
    for (int k = 0; k < 6; k++) pulse("R5 three-quarter rate");
  endtask

  task automatic t_dac;
    sampleInc = 17'h10000;
    pulse("R5 settle");
    chanOut = '0;
    chanOut[5] = 16'h0400;
    chanPan = '0;
    chanPan[5] = 2'b11;
    writeDac(8'hFF);
    pulse("R8 write while off ignored, R7 input used");
    chk("R7 channel 5 from input", 32'(sampleLeft), 32'h0200);
    setDacMode(1'b1);
    pulse("R7 override with held zero");
    chk("R8 earlier write dropped", 32'(sampleLeft), 32'h0000);
    writeDac(8'h00);
    pulse("R8 data 0x00");
    chk("R8 0x00 gives 0x7000", 32'(sampleRight), 32'h7000);
    writeDac(8'hFF);
    pulse("R8 data 0xFF");
    chk("R8 0xFF gives 0x0FE0", 32'(sampleLeft), 32'h0FE0);
    setDacMode(1'b0);
    pulse("R7 mode off restores input");
    writeDac(8'h40);
    setDacMode(1'b1);
    pulse("R8 off write ignored, value kept");
    chk("R8 kept 0x0FE0", 32'(sampleLeft), 32'h0FE0);
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_exactOne();
    t_shape();
    t_pan();
    t_wrap();
    t_rate();
    t_dac();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule